// File: doc/BRIEF.md
# Converter Host Register Interface

This block sits between a host processor and a sampling converter. The host sees an 8-bit parallel bus with three active-low strobes: chip select, write and read. A write word carries its own register address in its two top bits and six bits of control data below them. Two six-bit control registers hold the setup. Their fields are decoded into level signals that the conversion sequencer, clock selection and power logic use. Any write whose address selects no implemented register is dropped.

On the read side, the block keeps the most recent conversion result. When a read cycle opens, it takes a copy of that result. For as long as the read stays open, it drives the copy toward the bus through an output-enable signal that the pad ring turns into a tri-state driver. The copy goes out either as the straight unipolar code or in two's-complement form, which is the same code with its top bit flipped.

Boards that never write the registers can still set up the part. They tie the write strobe low and issue one dummy read. That returns both registers to all zeros: hardware start, interrupt status, internal clock, slow oscillator and binary output.

All strobes are sampled on the block clock. Edges are found by comparing each strobe with its value one clock earlier.

Top module: `adc_host_regs`

## Requirements
- R1: After asynchronous reset, every decoded field output is 0, `bus_oe` is 0 and `bus_out` is 0x00.
- R2: A write takes effect when `wr_n` is sampled high one clock after it was sampled low, with `cs_n` low in that clock. Bus bits 7:6 give the address: 00 selects register 0 and 01 selects register 1. Bits 5:0 become the register contents. Decoded outputs show the new value from the next clock onward.
- R3: A rising `wr_n` edge while `cs_n` is high changes no register.
- R4: A write with address 10 or 11 changes no register.
- R5: Register 0 decodes as follows. Bit 5 drives `start_sw`, bit 4 drives `status_eoc`, bit 3 drives `clk_ext` and bit 2 drives `pwr_down`. Bits 1:0 affect no output.
- R6: Register 1 decodes as follows. Bit 4 drives `osc_fast` and bit 1 drives `code_twos`. Bits 5, 3, 2 and 0 affect no output.
- R7: A falling `rd_n` edge with `cs_n` low while `wr_n` is low clears both registers to zero.
- R8: A falling `rd_n` edge with `cs_n` low opens a read. `bus_oe` is 1 from the next clock onward while `rd_n` and `cs_n` both stay low. It returns to 0 one clock after either of them goes high. `bus_out` is 0x00 whenever `bus_oe` is 0.
- R9: Each `conv_valid` pulse stores `conv_code` as the latest result. A read drives the result held when the read opened, even if a new result arrives while the read is open.
- R10: With `code_twos` at 0, `bus_out` equals the stored result. With `code_twos` at 1, `bus_out` is the stored result with bit 7 inverted, so 0x80 reads as 0x00 and 0x3F reads as 0xBF.
- R11: While `wr_n` stays low, changes on `bus_in` alter no field. A clock-source change appears only at the closing edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| bus_in | input | 8 | Data arriving from the host bus |
| conv_valid | input | 1 | One-clock pulse marking a finished conversion |
| conv_code | input | 8 | Unipolar conversion result |
| bus_out | output | 8 | Read data toward the host bus |
| bus_oe | output | 1 | Drive enable for the bus pads |
| start_sw | output | 1 | 1 = software start, 0 = hardware start pin |
| status_eoc | output | 1 | 1 = end-of-conversion level, 0 = interrupt pulse |
| clk_ext | output | 1 | 1 = external clock, 0 = internal oscillator |
| pwr_down | output | 1 | 1 = software power-down |
| osc_fast | output | 1 | 1 = fast internal oscillator |
| code_twos | output | 1 | 1 = two's-complement readback |

## Verification
The hardest case to reach from the ports is a new result arriving while a read is already open. From outside, this looks the same as a read that simply returns the latest value. The stimulus therefore opens a read, pulses `conv_valid` with a different code in the middle of it, and checks that the bus keeps the old value. It then closes the read and opens another one, which must return the new code. A second hard case is the dummy read with the write strobe held low, because it must clear the registers without an ordinary write edge. The bench loads non-zero values first, so that the clearing shows on every field output.

// File: rtl/adc_hostif_pkg.sv
package adc_hostif_pkg;

   // bit positions inside the six-bit control data field
   localparam int CR0_START_BIT  = 5;
   localparam int CR0_STATUS_BIT = 4;
   localparam int CR0_CLKSRC_BIT = 3;
   localparam int CR0_PDOWN_BIT  = 2;
   localparam int CR1_OSC_BIT    = 4;
   localparam int CR1_FMT_BIT    = 1;
   localparam int CFG_MIN_FIELD  = 6;

   typedef struct packed {
      logic start_sw;
      logic status_eoc;
      logic clk_ext;
      logic pwr_down;
      logic osc_fast;
      logic code_twos;
   } cfg_fields_t;

endpackage

// File: rtl/strobe_edges.sv
module strobe_edges #(
   parameter int NUM_STROBES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_STROBES-1:0] strb_n,
   output logic [NUM_STROBES-1:0] rise,
   output logic [NUM_STROBES-1:0] fall
);

   initial begin
      assert (NUM_STROBES >= 1) else $error("strobe_edges: NUM_STROBES must be at least 1");
   end

   for (genvar s = 0; s < NUM_STROBES; s++) begin : g_strobe
      logic prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b1;
         else        prev_q <= strb_n[s];
      end

      assign rise[s] = ~prev_q &  strb_n[s];
      assign fall[s] =  prev_q & ~strb_n[s];
   end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 2,
   parameter int NUM_REGS = 2,
   localparam int FIELD_W = DATA_W - ADDR_W
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic                             dflt_load,
   input  logic [DATA_W-1:0]                wdata,
   output logic [NUM_REGS-1:0][FIELD_W-1:0] regs_q
);

   logic [ADDR_W-1:0]  waddr;
   logic [FIELD_W-1:0] wfield;

   assign waddr  = wdata[DATA_W-1 -: ADDR_W];
   assign wfield = wdata[FIELD_W-1:0];

   initial begin
      assert (DATA_W > ADDR_W) else $error("cfg_regfile: DATA_W must exceed ADDR_W");
      assert (NUM_REGS >= 1 && NUM_REGS <= (1 << ADDR_W))
         else $error("cfg_regfile: NUM_REGS does not fit the address field");
   end

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic hit;
      assign hit = wr_en && (waddr == ADDR_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         regs_q[r] <= '0;
         else if (dflt_load) regs_q[r] <= '0;
         else if (hit)       regs_q[r] <= wfield;
      end

      AST_REG_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         (regs_q[r] != $past(regs_q[r])) |-> $past(wr_en || dflt_load)); // R3
      AST_DFLT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         dflt_load |=> (regs_q[r] == '0)); // R7
   end

   AST_BAD_ADDR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(waddr) >= NUM_REGS)) |=> $stable(regs_q)); // R4

endmodule

// File: rtl/result_port.sv
module result_port #(
   parameter int DATA_W   = 8,
   parameter bit SNAPSHOT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_valid,
   input  logic [DATA_W-1:0] conv_code,
   input  logic              rd_start,
   input  logic              rd_hold,
   input  logic              twos,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe
);

   localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

   logic [DATA_W-1:0] result_q;
   logic [DATA_W-1:0] src;
   logic              oe_q;

   initial begin
      assert (DATA_W >= 2) else $error("result_port: DATA_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          result_q <= '0;
      else if (conv_valid) result_q <= conv_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= rd_hold & (oe_q | rd_start);
   end

   if (SNAPSHOT) begin : g_snap
      logic [DATA_W-1:0] snap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        snap_q <= '0;
         else if (rd_start) snap_q <= result_q;
      end
      assign src = snap_q;

      AST_READ_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_oe && $past(bus_oe) && $stable(twos)) |-> $stable(bus_out)); // R9
   end else begin : g_live
      assign src = result_q;
   end

   assign bus_oe  = oe_q;
   assign bus_out = oe_q ? (src ^ (twos ? MSB_MASK : '0)) : '0;

   AST_OE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> $past(rd_hold)); // R8
   AST_OE_OPENS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe) |-> $past(rd_start)); // R8

endmodule

// File: rtl/adc_host_regs.sv
module adc_host_regs
   import adc_hostif_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 2,
   parameter int NUM_REGS = 2,
   parameter bit SNAPSHOT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic [DATA_W-1:0] bus_in,
   input  logic              conv_valid,
   input  logic [DATA_W-1:0] conv_code,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              start_sw,
   output logic              status_eoc,
   output logic              clk_ext,
   output logic              pwr_down,
   output logic              osc_fast,
   output logic              code_twos
);

   localparam int FIELD_W = DATA_W - ADDR_W;
   localparam int IDX_WR  = 0;
   localparam int IDX_RD  = 1;

   logic [1:0] strb_rise;
   logic [1:0] strb_fall;
   logic       wr_en;
   logic       dflt_load;
   logic       rd_start;
   logic       rd_hold;
   logic [NUM_REGS-1:0][FIELD_W-1:0] regs_q;
   cfg_fields_t cfg;

   initial begin
      assert (NUM_REGS >= 2) else $error("adc_host_regs: two control registers are required");
      assert (FIELD_W >= CFG_MIN_FIELD) else $error("adc_host_regs: control field too narrow");
   end

   strobe_edges #(.NUM_STROBES(2)) i_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .strb_n({rd_n, wr_n}),
      .rise  (strb_rise),
      .fall  (strb_fall)
   );

   assign wr_en     = strb_rise[IDX_WR] & ~cs_n;
   assign rd_start  = strb_fall[IDX_RD] & ~cs_n;
   assign dflt_load = rd_start & ~wr_n;
   assign rd_hold   = ~cs_n & ~rd_n;

   cfg_regfile #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .NUM_REGS(NUM_REGS)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .dflt_load(dflt_load),
      .wdata    (bus_in),
      .regs_q   (regs_q)
   );

   always_comb begin
      cfg.start_sw   = regs_q[0][CR0_START_BIT];
      cfg.status_eoc = regs_q[0][CR0_STATUS_BIT];
      cfg.clk_ext    = regs_q[0][CR0_CLKSRC_BIT];
      cfg.pwr_down   = regs_q[0][CR0_PDOWN_BIT];
      cfg.osc_fast   = regs_q[1][CR1_OSC_BIT];
      cfg.code_twos  = regs_q[1][CR1_FMT_BIT];
   end

   assign start_sw   = cfg.start_sw;
   assign status_eoc = cfg.status_eoc;
   assign clk_ext    = cfg.clk_ext;
   assign pwr_down   = cfg.pwr_down;
   assign osc_fast   = cfg.osc_fast;
   assign code_twos  = cfg.code_twos;

   logic unused_bits;
   assign unused_bits = ^{regs_q, strb_rise[IDX_RD], strb_fall[IDX_WR]};

   result_port #(
      .DATA_W  (DATA_W),
      .SNAPSHOT(SNAPSHOT)
   ) i_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_valid(conv_valid),
      .conv_code (conv_code),
      .rd_start  (rd_start),
      .rd_hold   (rd_hold),
      .twos      (cfg.code_twos),
      .bus_out   (bus_out),
      .bus_oe    (bus_oe)
   );

   AST_WR_LOW_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && $past(!wr_n) && !$past(dflt_load)) |-> $stable(cfg)); // R11
   AST_CFG_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg != $past(cfg)) |-> $past(!cs_n)); // R3

endmodule

// File: tb/test_adc_host_regs.sv
module test_adc_host_regs;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
   logic [7:0] bus_in = 8'h00;
   logic       conv_valid = 1'b0;
   logic [7:0] conv_code = 8'h00;
   logic [7:0] bus_out;
   logic       bus_oe, start_sw, status_eoc, clk_ext, pwr_down, osc_fast, code_twos;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   adc_host_regs i_adc_host_regs (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .bus_in(bus_in), .conv_valid(conv_valid), .conv_code(conv_code),
      .bus_out(bus_out), .bus_oe(bus_oe), .start_sw(start_sw),
      .status_eoc(status_eoc), .clk_ext(clk_ext), .pwr_down(pwr_down),
      .osc_fast(osc_fast), .code_twos(code_twos)
   );

   // behavioural reference model
   logic [5:0] m_r0, m_r1;
   logic [7:0] m_res, m_snap;
   logic       m_oe, m_wrp, m_rdp;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_r0 = 6'h0; m_r1 = 6'h0; m_res = 8'h0; m_snap = 8'h0;
         m_oe = 1'b0; m_wrp = 1'b1; m_rdp = 1'b1;
      end else begin
         logic wr_edge, rd_edge, nxt_oe;
         wr_edge = !m_wrp && wr_n;
         rd_edge = m_rdp && !rd_n;
         nxt_oe  = !cs_n && !rd_n && (m_oe || rd_edge);
         if (rd_edge && !cs_n) m_snap = m_res;
         if (conv_valid) m_res = conv_code;
         if (rd_edge && !cs_n && !wr_n) begin
            m_r0 = 6'h0; m_r1 = 6'h0;
         end else if (wr_edge && !cs_n) begin
            if (bus_in[7:6] == 2'b00) m_r0 = bus_in[5:0];
            else if (bus_in[7:6] == 2'b01) m_r1 = bus_in[5:0];
         end
         m_oe = nxt_oe; m_wrp = wr_n; m_rdp = rd_n;
      end
   end

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         logic [7:0] exp_out;
         exp_out = m_oe ? (m_snap ^ {m_r1[1], 7'b0}) : 8'h00;
         chk("R5", "cycle reg0 fields", {4'b0, start_sw, status_eoc, clk_ext, pwr_down},
             {4'b0, m_r0[5], m_r0[4], m_r0[3], m_r0[2]});
         chk("R6", "cycle reg1 fields", {6'b0, osc_fast, code_twos}, {6'b0, m_r1[4], m_r1[1]});
         chk("R8", "cycle bus_oe", {7'b0, bus_oe}, {7'b0, m_oe});
         chk("R10", "cycle bus_out", bus_out, exp_out);
      end
   end

   function automatic logic [7:0] fields();
      return {2'b0, start_sw, status_eoc, clk_ext, pwr_down, osc_fast, code_twos};
   endfunction

   task automatic do_write(input logic [7:0] d, input logic use_cs);
      @(negedge clk); cs_n = !use_cs; wr_n = 1'b0; bus_in = d;
      @(negedge clk); wr_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
   endtask

   task automatic do_read(output logic [7:0] d);
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
      @(negedge clk); d = bus_out;
      rd_n = 1'b1; cs_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic put_result(input logic [7:0] c);
      @(negedge clk); conv_valid = 1'b1; conv_code = c;
      @(negedge clk); conv_valid = 1'b0;
   endtask

   initial begin
      while (cycles < 100000) @(negedge clk);
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      chk("R1", "reset bus_oe", {7'b0, bus_oe}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset fields", fields(), 8'h00);
      chk("R1", "reset bus_out", bus_out, 8'h00);

      do_write(8'h38, 1'b1);
      chk("R2", "reg0 write 0x38", fields(), 8'b0011_1000 >> 0 & 8'h3C);
      do_write(8'h04, 1'b1);
      chk("R5", "power-down only", fields(), 8'h04);
      do_write(8'h52, 1'b1);
      chk("R6", "osc fast + twos", fields(), 8'h07);
      do_write(8'h6D, 1'b1);
      chk("R6", "reserved bits no effect", fields(), 8'h04);

      do_write(8'h3C, 1'b0);
      chk("R3", "write without cs", fields(), 8'h04);
      do_write(8'hBC, 1'b1);
      chk("R4", "address 10 ignored", fields(), 8'h04);
      do_write(8'hFF, 1'b1);
      chk("R4", "address 11 ignored", fields(), 8'h04);

      // R11: clock source changes only at the closing write edge
      @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; bus_in = 8'h08;
      repeat (2) @(negedge clk);
      chk("R11", "clk_ext held while wr low", {7'b0, clk_ext}, 8'h00);
      bus_in = 8'h3C;
      @(negedge clk);
      chk("R11", "fields held on data change", fields(), 8'h04);
      bus_in = 8'h08;
      @(negedge clk); wr_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
      chk("R11", "clk_ext after edge", fields(), 8'h08);

      put_result(8'h80);
      do_read(rd);
      chk("R10", "binary 0x80", rd, 8'h80);
      do_write(8'h42, 1'b1);
      do_read(rd);
      chk("R10", "twos 0x80", rd, 8'h00);
      put_result(8'h3F);
      do_read(rd);
      chk("R10", "twos 0x3F", rd, 8'hBF);
      do_write(8'h40, 1'b1);

      // R9: new result during an open read
      put_result(8'h5A);
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
      @(negedge clk); conv_valid = 1'b1; conv_code = 8'hC3;
      @(negedge clk); conv_valid = 1'b0;
      chk("R9", "snapshot held", bus_out, 8'h5A);
      rd_n = 1'b1; cs_n = 1'b1;
      @(negedge clk);
      chk("R8", "bus quiet after read", {bus_oe, bus_out[6:0]}, 8'h00);
      do_read(rd);
      chk("R9", "next read new result", rd, 8'hC3);

      @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8", "no drive without cs", {7'b0, bus_oe}, 8'h00);
      rd_n = 1'b1;

      do_write(8'h3C, 1'b1);
      do_write(8'h52, 1'b1);
      chk("R7", "preload", fields(), 8'h3F);
      @(negedge clk); cs_n = 1'b0; wr_n = 1'b0;
      @(negedge clk); rd_n = 1'b0;
      @(negedge clk);
      chk("R7", "dummy read clears", fields(), 8'h00);
      rd_n = 1'b1;
      @(negedge clk); cs_n = 1'b1; bus_in = 8'h00;
      repeat (3) @(negedge clk);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule